// File: doc/BRIEF.md
# Round-Robin Burst Conversion Sequencer

This block drives a single analog-to-digital converter through a table of sixteen conversion slots. Each slot names an input channel and the length of its acquisition window. A trigger starts a burst. The burst converts a programmed number of consecutive slots, one after another. The first slot of each burst is taken from a round-robin pointer, and that pointer keeps its value from one trigger to the next. A burst that is shorter than the table therefore begins at a different slot each time it is triggered.

The analog part is replaced by a fixed-latency model. At the last acquisition clock of a slot, the block captures the `samp_in` input. Ten clocks later it writes that value into the result entry of the slot. One slot number can be chosen to raise an interrupt flag, either at the end of sampling or after the result has been written. A missed flag clear is reported as an interrupt overflow. A trigger that arrives during a burst is held once and run as soon as the current burst ends. A further trigger that arrives while one is already held raises a trigger-overflow flag.

Top module: `rr_burst_seq`

## Requirements
- R1: After a synchronous reset, `busy`, `acq_active`, `int_flag`, `int_ovf` and `trig_ovf` are 0, and `rr_ptr` is 0.
- R2: A trigger seen while idle starts a burst of `burst_len`+1 slots. The first slot is `rr_ptr`, and each later slot is the previous one plus 1, with slot 15 followed by slot 0. When the burst ends, `rr_ptr` holds the slot after the last one converted.
- R3: Slots convert strictly one at a time. Each slot spends acq+1 clocks with `acq_active` high, then 10 conversion clocks. The next slot starts immediately after that, so `busy` stays high for the sum of (acq+11) over the slots of the burst.
- R4: A slot's result entry holds the value of `samp_in` from that slot's last acquisition clock. `rd_data` shows the entry selected by `rd_slot` one clock after it is addressed.
- R5: During a slot's acquisition, `conv_chan` holds the channel written to that slot through the configuration port (`cfg_we`, `cfg_slot`, `cfg_chan`, `cfg_acq`).
- R6: When `int_en` is 1 and the selected slot `int_slot` finishes, `int_flag` sets. With `int_late` at 0, it sets at the edge that ends acquisition. With `int_late` at 1, it sets at the edge that writes the result, 10 clocks later. With `int_en` at 0, the flag does not set.
- R7: `flag_clr` at 1 clears `int_flag` at the next edge. If a set event arrives in the same cycle, the set wins.
- R8: An interrupt event that arrives while `int_flag` is already 1 sets `int_ovf`. `ovf_clr` at 1 clears `int_ovf` and `trig_ovf`.
- R9: A single trigger that arrives during a burst is held. The next burst starts in the same cycle the current burst ends, from the updated pointer, so `busy` does not drop between the two.
- R10: A trigger that arrives while one is already held sets `trig_ovf` and is discarded, so only one extra burst runs.
- R11: An acquisition value of 14 gives a window of exactly 15 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trig | input | 1 | Start-of-burst request, one cycle per trigger |
| burst_len | input | 4 | Slots per burst minus one |
| cfg_we | input | 1 | Write strobe for the slot table |
| cfg_slot | input | 4 | Slot written |
| cfg_chan | input | 4 | Channel for the written slot |
| cfg_acq | input | 9 | Acquisition value for the written slot (window = value+1 clocks) |
| int_slot | input | 4 | Slot whose completion raises the interrupt |
| int_en | input | 1 | Interrupt enable |
| int_late | input | 1 | 0: flag at end of sampling, 1: flag after result write |
| flag_clr | input | 1 | Clear of `int_flag` |
| ovf_clr | input | 1 | Clear of `int_ovf` and `trig_ovf` |
| samp_in | input | 12 | Sample value presented to the converter model |
| rd_slot | input | 4 | Result entry to read |
| rd_data | output | 12 | Registered result of `rd_slot` |
| conv_chan | output | 4 | Channel under acquisition |
| acq_active | output | 1 | High during acquisition clocks |
| busy | output | 1 | High while a burst runs |
| rr_ptr | output | 4 | Start slot of the next burst |
| int_flag | output | 1 | Interrupt flag |
| int_ovf | output | 1 | Interrupt overflow |
| trig_ovf | output | 1 | Trigger overflow |

## Verification
The bench builds the block with its default parameters: 16 slots, 4-bit channels, 9-bit acquisition values, 12-bit results and a 10-clock conversion latency. It sweeps every burst length from 1 to 16 slots in turn. The starting pointer therefore moves through many positions and wraps past slot 15 several times. The slot table mixes short windows with the 14-clock value. The sample input is a function of the presented channel and of a per-burst tag, so every result entry shows which burst wrote it, which channel fed it and whether it was skipped. The interrupt timing, the overflow flags and the held trigger are each measured in clocks against offsets the bench computes from the slot table.

// File: rtl/rrb_pkg.sv
`timescale 1ns/1ps
package rrb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ACQ  = 2'd1,
    ST_CONV = 2'd2
  } seq_state_t;
endpackage

// File: rtl/rrb_cfg_regs.sv
`timescale 1ns/1ps
// Slot table: channel and acquisition value per slot, asynchronous read.
module rrb_cfg_regs #(
  parameter int NSLOT = 16,
  parameter int SL_W  = $clog2(NSLOT),
  parameter int CH_W  = 4,
  parameter int ACQ_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [SL_W-1:0]  wslot,
  input  logic [CH_W-1:0]  wchan,
  input  logic [ACQ_W-1:0] wacq,
  input  logic [SL_W-1:0]  rslot,
  output logic [CH_W-1:0]  rchan,
  output logic [ACQ_W-1:0] racq
);
  logic [CH_W-1:0]  chan_r [NSLOT];
  logic [ACQ_W-1:0] acq_r  [NSLOT];

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst) begin
        chan_r[g] <= '0;
        acq_r[g]  <= '0;
      end else if (we && wslot == SL_W'(g)) begin
        chan_r[g] <= wchan;
        acq_r[g]  <= wacq;
      end
    end
  end

  assign rchan = chan_r[rslot];
  assign racq  = acq_r[rslot];
endmodule

// File: rtl/rrb_result_ram.sv
`timescale 1ns/1ps
// Per-slot result storage: one write port, one registered read port.
module rrb_result_ram #(
  parameter int NSLOT = 16,
  parameter int SL_W  = $clog2(NSLOT),
  parameter int RES_W = 12
) (
  input  logic             clk,
  input  logic             we,
  input  logic [SL_W-1:0]  waddr,
  input  logic [RES_W-1:0] wdata,
  input  logic [SL_W-1:0]  raddr,
  output logic [RES_W-1:0] rdata
);
  logic [RES_W-1:0] mem [NSLOT];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/rrb_seq_ctrl.sv
`timescale 1ns/1ps
// Burst walker: acquisition/conversion timing, round-robin pointer,
// held trigger and trigger overflow.
module rrb_seq_ctrl
  import rrb_pkg::*;
#(
  parameter int NSLOT    = 16,
  parameter int SL_W     = $clog2(NSLOT),
  parameter int CH_W     = 4,
  parameter int ACQ_W    = 9,
  parameter int RES_W    = 12,
  parameter int CONV_LAT = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             trig,
  input  logic [SL_W-1:0]  burst_len,
  input  logic             ovf_clr,
  input  logic [CH_W-1:0]  cfg_chan,
  input  logic [ACQ_W-1:0] cfg_acq,
  output logic [SL_W-1:0]  ld_slot,
  input  logic [RES_W-1:0] samp_in,
  output logic             busy,
  output logic             acq_active,
  output logic [CH_W-1:0]  conv_chan,
  output logic [SL_W-1:0]  cur_slot,
  output logic             ev_samp,
  output logic             ev_write,
  output logic [RES_W-1:0] wr_data,
  output logic [SL_W-1:0]  rr_ptr,
  output logic             trig_ovf
);
  localparam int CL_W  = $clog2(CONV_LAT);
  localparam int CNT_W = (ACQ_W > CL_W) ? ACQ_W : CL_W;
  localparam logic [CNT_W-1:0] CONV_LAST = CNT_W'(CONV_LAT - 1);
  localparam logic [SL_W-1:0]  SLOT_TOP  = SL_W'(NSLOT - 1);

  seq_state_t       state;
  logic [SL_W-1:0]  cur, left, rr_q, nxt;
  logic [CNT_W-1:0] cnt;
  logic [ACQ_W-1:0] acq_q;
  logic [CH_W-1:0]  chan_q;
  logic [RES_W-1:0] samp_q;
  logic             pend, tovf;
  logic             acq_done, conv_done, burst_end, busy_trig;

  assign nxt       = (cur == SLOT_TOP) ? '0 : cur + 1'b1;
  assign ld_slot   = (state == ST_IDLE) ? rr_q : nxt;
  assign acq_done  = (state == ST_ACQ)  && (cnt == CNT_W'(acq_q));
  assign conv_done = (state == ST_CONV) && (cnt == CONV_LAST);
  assign burst_end = conv_done && (left == '0);
  assign busy_trig = trig && (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      cur    <= '0;
      left   <= '0;
      cnt    <= '0;
      acq_q  <= '0;
      chan_q <= '0;
      samp_q <= '0;
      rr_q   <= '0;
      pend   <= 1'b0;
      tovf   <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (trig) begin
            state  <= ST_ACQ;
            cur    <= rr_q;
            left   <= burst_len;
            cnt    <= '0;
            chan_q <= cfg_chan;
            acq_q  <= cfg_acq;
          end
        end
        ST_ACQ: begin
          if (acq_done) begin
            samp_q <= samp_in;
            state  <= ST_CONV;
            cnt    <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_CONV: begin
          if (conv_done) begin
            cnt    <= '0;
            cur    <= nxt;
            chan_q <= cfg_chan;
            acq_q  <= cfg_acq;
            if (left != '0) begin
              left  <= left - 1'b1;
              state <= ST_ACQ;
            end else begin
              rr_q <= nxt;
              if (pend || trig) begin
                left  <= burst_len;
                state <= ST_ACQ;
              end else begin
                state <= ST_IDLE;
              end
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase

      // held trigger: consumed at burst end, a fresh one in that cycle stays held
      if (burst_end)      pend <= pend && trig;
      else if (busy_trig) pend <= 1'b1;

      if (busy_trig && !burst_end && pend) tovf <= 1'b1;
      else if (ovf_clr)                    tovf <= 1'b0;
    end
  end

  assign busy       = (state != ST_IDLE);
  assign acq_active = (state == ST_ACQ);
  assign conv_chan  = chan_q;
  assign cur_slot   = cur;
  assign ev_samp    = acq_done;
  assign ev_write   = conv_done;
  assign wr_data    = samp_q;
  assign rr_ptr     = rr_q;
  assign trig_ovf   = tovf;
endmodule

// File: rtl/rrb_irq.sv
`timescale 1ns/1ps
// End-of-conversion interrupt flag with selectable pulse position.
module rrb_irq #(
  parameter int NSLOT = 16,
  parameter int SL_W  = $clog2(NSLOT)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ev_samp,
  input  logic            ev_write,
  input  logic [SL_W-1:0] ev_slot,
  input  logic [SL_W-1:0] sel_slot,
  input  logic            en,
  input  logic            late,
  input  logic            flag_clr,
  input  logic            ovf_clr,
  output logic            flag,
  output logic            ovf
);
  logic ev, hit;

  assign ev  = late ? ev_write : ev_samp;
  assign hit = ev && en && (ev_slot == sel_slot);

  always_ff @(posedge clk) begin
    if (rst) begin
      flag <= 1'b0;
      ovf  <= 1'b0;
    end else begin
      if (hit)           flag <= 1'b1;
      else if (flag_clr) flag <= 1'b0;

      if (hit && flag)   ovf <= 1'b1;
      else if (ovf_clr)  ovf <= 1'b0;
    end
  end
endmodule

// File: rtl/rr_burst_seq.sv
`timescale 1ns/1ps
module rr_burst_seq #(
  parameter int NSLOT    = 16,
  parameter int SL_W     = $clog2(NSLOT),
  parameter int CH_W     = 4,
  parameter int ACQ_W    = 9,
  parameter int RES_W    = 12,
  parameter int CONV_LAT = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             trig,
  input  logic [SL_W-1:0]  burst_len,
  input  logic             cfg_we,
  input  logic [SL_W-1:0]  cfg_slot,
  input  logic [CH_W-1:0]  cfg_chan,
  input  logic [ACQ_W-1:0] cfg_acq,
  input  logic [SL_W-1:0]  int_slot,
  input  logic             int_en,
  input  logic             int_late,
  input  logic             flag_clr,
  input  logic             ovf_clr,
  input  logic [RES_W-1:0] samp_in,
  input  logic [SL_W-1:0]  rd_slot,
  output logic [RES_W-1:0] rd_data,
  output logic [CH_W-1:0]  conv_chan,
  output logic             acq_active,
  output logic             busy,
  output logic [SL_W-1:0]  rr_ptr,
  output logic             int_flag,
  output logic             int_ovf,
  output logic             trig_ovf
);
  logic [SL_W-1:0]  ld_slot, cur_slot;
  logic [CH_W-1:0]  ld_chan;
  logic [ACQ_W-1:0] ld_acq;
  logic             ev_samp, ev_write;
  logic [RES_W-1:0] wr_data;

  rrb_cfg_regs #(.NSLOT(NSLOT), .SL_W(SL_W), .CH_W(CH_W), .ACQ_W(ACQ_W)) u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .wslot(cfg_slot), .wchan(cfg_chan),
    .wacq(cfg_acq), .rslot(ld_slot), .rchan(ld_chan), .racq(ld_acq)
  );

  rrb_seq_ctrl #(.NSLOT(NSLOT), .SL_W(SL_W), .CH_W(CH_W), .ACQ_W(ACQ_W),
                 .RES_W(RES_W), .CONV_LAT(CONV_LAT)) u_ctrl (
    .clk(clk), .rst(rst), .trig(trig), .burst_len(burst_len), .ovf_clr(ovf_clr),
    .cfg_chan(ld_chan), .cfg_acq(ld_acq), .ld_slot(ld_slot), .samp_in(samp_in),
    .busy(busy), .acq_active(acq_active), .conv_chan(conv_chan),
    .cur_slot(cur_slot), .ev_samp(ev_samp), .ev_write(ev_write),
    .wr_data(wr_data), .rr_ptr(rr_ptr), .trig_ovf(trig_ovf)
  );

  rrb_result_ram #(.NSLOT(NSLOT), .SL_W(SL_W), .RES_W(RES_W)) u_res (
    .clk(clk), .we(ev_write), .waddr(cur_slot), .wdata(wr_data),
    .raddr(rd_slot), .rdata(rd_data)
  );

  rrb_irq #(.NSLOT(NSLOT), .SL_W(SL_W)) u_irq (
    .clk(clk), .rst(rst), .ev_samp(ev_samp), .ev_write(ev_write),
    .ev_slot(cur_slot), .sel_slot(int_slot), .en(int_en), .late(int_late),
    .flag_clr(flag_clr), .ovf_clr(ovf_clr), .flag(int_flag), .ovf(int_ovf)
  );
endmodule

// File: rtl/rrb_checker.sv
`timescale 1ns/1ps
module rrb_checker #(
  parameter int SL_W = 4,
  parameter int CH_W = 4
) (
  input logic            clk,
  input logic            rst,
  input logic            trig,
  input logic            busy,
  input logic            acq_active,
  input logic [CH_W-1:0] conv_chan,
  input logic [SL_W-1:0] rr_ptr,
  input logic            int_en,
  input logic            int_flag,
  input logic            int_ovf,
  input logic            trig_ovf
);
  logic past_ok;
  always_ff @(posedge clk) begin
    if (rst) past_ok <= 1'b0;
    else     past_ok <= 1'b1;
  end

  a_r3_burst_opens_with_acq: assert property (@(posedge clk) disable iff (rst)
    past_ok && $rose(busy) |-> acq_active);

  a_r3_acq_only_when_busy: assert property (@(posedge clk) disable iff (rst)
    acq_active |-> busy);

  a_r5_chan_held_in_window: assert property (@(posedge clk) disable iff (rst)
    past_ok && acq_active && $past(acq_active) |-> $stable(conv_chan));

  a_r6_flag_needs_enable: assert property (@(posedge clk) disable iff (rst)
    past_ok && $rose(int_flag) |-> $past(int_en) && $past(busy));

  a_r8_ovf_needs_flag: assert property (@(posedge clk) disable iff (rst)
    past_ok && $rose(int_ovf) |-> $past(int_flag));

  a_r2_ptr_moves_in_burst: assert property (@(posedge clk) disable iff (rst)
    past_ok && (rr_ptr != $past(rr_ptr)) |-> $past(busy));

  a_r10_tovf_needs_busy_trig: assert property (@(posedge clk) disable iff (rst)
    past_ok && $rose(trig_ovf) |-> $past(busy) && $past(trig));
endmodule

bind rr_burst_seq rrb_checker #(.SL_W(SL_W), .CH_W(CH_W)) u_chk (
  .clk(clk), .rst(rst), .trig(trig), .busy(busy), .acq_active(acq_active),
  .conv_chan(conv_chan), .rr_ptr(rr_ptr), .int_en(int_en), .int_flag(int_flag),
  .int_ovf(int_ovf), .trig_ovf(trig_ovf)
);

// File: tb/sim_rr_burst_seq.sv
`timescale 1ns/1ps
module sim_rr_burst_seq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        trig = 1'b0;
  logic [3:0]  burst_len = '0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_slot = '0;
  logic [3:0]  cfg_chan = '0;
  logic [8:0]  cfg_acq = '0;
  logic [3:0]  int_slot = '0;
  logic        int_en = 1'b0;
  logic        int_late = 1'b0;
  logic        flag_clr = 1'b0;
  logic        ovf_clr = 1'b0;
  logic [11:0] samp_in;
  logic [3:0]  rd_slot = '0;
  logic [11:0] rd_data;
  logic [3:0]  conv_chan;
  logic        acq_active, busy, int_flag, int_ovf, trig_ovf;
  logic [3:0]  rr_ptr;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  int bias = 0;

  always #10 clk = ~clk;

  // converter input: depends on presented channel and a per-burst tag
  assign samp_in = 12'((int'(conv_chan) * 97 + bias * 5 + 3) % 4096);

  rr_burst_seq u0 (
    .clk(clk), .rst(rst), .trig(trig), .burst_len(burst_len), .cfg_we(cfg_we),
    .cfg_slot(cfg_slot), .cfg_chan(cfg_chan), .cfg_acq(cfg_acq),
    .int_slot(int_slot), .int_en(int_en), .int_late(int_late),
    .flag_clr(flag_clr), .ovf_clr(ovf_clr), .samp_in(samp_in),
    .rd_slot(rd_slot), .rd_data(rd_data), .conv_chan(conv_chan),
    .acq_active(acq_active), .busy(busy), .rr_ptr(rr_ptr),
    .int_flag(int_flag), .int_ovf(int_ovf), .trig_ovf(trig_ovf)
  );

  function automatic int s_acq(int s);
    return (s == 5) ? 14 : (s % 3);
  endfunction
  function automatic int s_ch(int s);
    return (s * 5 + 3) % 16;
  endfunction
  function automatic int exp_val(int ch, int b);
    return (ch * 97 + b * 5 + 3) % 4096;
  endfunction
  function automatic int burst_t(int st, int len);
    int t = 0;
    for (int i = 0; i <= len; i++) t += s_acq((st + i) % 16) + 11;
    return t;
  endfunction
  function automatic int acq_t(int st, int len);
    int t = 0;
    for (int i = 0; i <= len; i++) t += s_acq((st + i) % 16) + 1;
    return t;
  endfunction
  function automatic int ev_off(int st, int p, bit late);
    int t = 0;
    for (int i = 0; i < p; i++) t += s_acq((st + i) % 16) + 11;
    t += s_acq((st + p) % 16) + 1 + (late ? 10 : 0);
    return t;
  endfunction

  task automatic chk(string req, int act, int expv);
    total++;
    if (act != expv) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic pulse_trig();
    @(negedge clk); trig = 1'b1;
    @(negedge clk); trig = 1'b0;
  endtask

  // walks the burst from sample 1; optional extra triggers at samples 3 and 5
  task automatic measure(input int n_extra, output int bn, output int an,
                         output int fk, output int fh);
    int k;
    bn = 0; an = 0; fk = 0; fh = 0; k = 1;
    while (busy) begin
      bn++;
      if (acq_active) an++;
      if (int_flag) begin
        fh++;
        if (fk == 0) fk = k;
      end
      trig = (n_extra >= 1 && k == 3) || (n_extra >= 2 && k == 5);
      @(negedge clk);
      k++;
    end
    trig = 1'b0;
  endtask

  task automatic read_slot(input int s, output int v);
    @(negedge clk); rd_slot = 4'(s);
    @(negedge clk); v = int'(rd_data);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int ptr_m, bn, an, fk, fh, v;
    int exp_res [16];
    bit wr_ok [16];
    for (int s = 0; s < 16; s++) wr_ok[s] = 1'b0;
    ptr_m = 0;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 busy", int'(busy), 0);
    chk("R1 acq_active", int'(acq_active), 0);
    chk("R1 rr_ptr", int'(rr_ptr), 0);
    chk("R1 int_flag", int'(int_flag), 0);
    chk("R1 int_ovf", int'(int_ovf), 0);
    chk("R1 trig_ovf", int'(trig_ovf), 0);

    for (int s = 0; s < 16; s++) begin
      @(negedge clk);
      cfg_we = 1'b1; cfg_slot = 4'(s); cfg_chan = 4'(s_ch(s)); cfg_acq = 9'(s_acq(s));
    end
    @(negedge clk); cfg_we = 1'b0;

    // sweep all burst lengths; pointer walks and wraps
    for (int b = 0; b < 16; b++) begin
      burst_len = 4'(b);
      bias = b;
      pulse_trig();
      measure(0, bn, an, fk, fh);
      chk("R3 busy length", bn, burst_t(ptr_m, b));
      chk("R3 R11 acquisition clocks", an, acq_t(ptr_m, b));
      for (int i = 0; i <= b; i++) begin
        exp_res[(ptr_m + i) % 16] = exp_val(s_ch((ptr_m + i) % 16), b);
        wr_ok[(ptr_m + i) % 16] = 1'b1;
      end
      ptr_m = (ptr_m + b + 1) % 16;
      chk("R2 rr_ptr after burst", int'(rr_ptr), ptr_m);
      for (int s = 0; s < 16; s++) begin
        if (wr_ok[s]) begin
          read_slot(s, v);
          chk("R4 R5 R2 result entry", v, exp_res[s]);
        end
      end
    end

    // R6 early position
    int_en = 1'b1; int_late = 1'b0; burst_len = 4'd3;
    int_slot = 4'((ptr_m + 2) % 16);
    pulse_trig();
    measure(0, bn, an, fk, fh);
    chk("R6 early flag clock", fk, ev_off(ptr_m, 2, 1'b0) + 1);
    chk("R6 flag held", int'(int_flag), 1);
    ptr_m = (ptr_m + 4) % 16;
    @(negedge clk); flag_clr = 1'b1;
    @(negedge clk); flag_clr = 1'b0;
    chk("R7 flag cleared", int'(int_flag), 0);
    chk("R8 no overflow", int'(int_ovf), 0);

    // R6 late position
    int_late = 1'b1;
    int_slot = 4'((ptr_m + 1) % 16);
    pulse_trig();
    measure(0, bn, an, fk, fh);
    chk("R6 late flag clock", fk, ev_off(ptr_m, 1, 1'b1) + 1);
    ptr_m = (ptr_m + 4) % 16;

    // R8: flag left set, another event
    int_slot = 4'((ptr_m + 2) % 16);
    pulse_trig();
    measure(0, bn, an, fk, fh);
    chk("R8 interrupt overflow", int'(int_ovf), 1);
    ptr_m = (ptr_m + 4) % 16;
    @(negedge clk); ovf_clr = 1'b1; flag_clr = 1'b1;
    @(negedge clk); ovf_clr = 1'b0; flag_clr = 1'b0;
    chk("R8 overflow cleared", int'(int_ovf), 0);
    chk("R7 flag cleared again", int'(int_flag), 0);

    // R6 disabled
    int_en = 1'b0;
    int_slot = 4'((ptr_m + 1) % 16);
    pulse_trig();
    measure(0, bn, an, fk, fh);
    chk("R6 disabled flag", int'(int_flag), 0);
    ptr_m = (ptr_m + 4) % 16;

    // R7 set wins over a held clear
    int_en = 1'b1; int_late = 1'b1;
    int_slot = 4'((ptr_m + 1) % 16);
    @(negedge clk); flag_clr = 1'b1;
    pulse_trig();
    measure(0, bn, an, fk, fh);
    chk("R7 set beats clear clock", fk, ev_off(ptr_m, 1, 1'b1) + 1);
    chk("R7 one flag clock", fh, 1);
    chk("R7 cleared after", int'(int_flag), 0);
    flag_clr = 1'b0;
    ptr_m = (ptr_m + 4) % 16;
    int_en = 1'b0;

    // R9 held trigger
    burst_len = 4'd1;
    pulse_trig();
    measure(1, bn, an, fk, fh);
    chk("R9 back-to-back length", bn, burst_t(ptr_m, 1) + burst_t((ptr_m + 2) % 16, 1));
    chk("R9 no trigger overflow", int'(trig_ovf), 0);
    ptr_m = (ptr_m + 4) % 16;
    chk("R9 pointer after two", int'(rr_ptr), ptr_m);

    // R10 second held trigger
    pulse_trig();
    measure(2, bn, an, fk, fh);
    chk("R10 only one extra burst", bn, burst_t(ptr_m, 1) + burst_t((ptr_m + 2) % 16, 1));
    chk("R10 trigger overflow", int'(trig_ovf), 1);
    ptr_m = (ptr_m + 4) % 16;
    chk("R10 pointer", int'(rr_ptr), ptr_m);
    @(negedge clk); ovf_clr = 1'b1;
    @(negedge clk); ovf_clr = 1'b0;
    chk("R8 trig overflow cleared", int'(trig_ovf), 0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule